// File: doc/BRIEF.md
# Doubled-Pixel VGA Scan Generator and Frame Fetch

This block produces the raster for a 640x480 display refreshed at 60 Hz. It runs from a system clock and a pixel-step enable that is asserted at the 25 MHz pixel rate. From this it generates active-low horizontal and vertical sync, an active-video flag, and the current scan coordinates. It also drives the read side of an external 320x240 frame buffer that holds one 12-bit RGB444 pixel per word. Each stored pixel is shown as a 2x2 square, so the quarter-resolution picture fills the whole screen.

The memory is outside the block and has a one-cycle synchronous read. A read is issued only on a pixel step, only in the visible area, and only while the display-mode input is high. Sync, active-video and the captured mode are delayed by one pixel step so that they line up with the returned word. The 4-bit red, green and blue outputs come from that word while the delayed active flag and the delayed mode are both set. At all other times they are zero.

All timing figures are parameters. The defaults are: 640 visible, 16 front porch, 96 sync and 48 back porch, for 800 clocks per line. Vertically: 480 visible, 10 front porch, 2 sync and 33 back porch, for 525 lines per frame.

Top module: `vga_scan_fetch`

## Requirements
- R1: While reset is high and after it is released, before any pixel step, hSync and vSync are high, active is low, red/green/blue are zero, and xPos and yPos are zero.
- R2: Each cycle with pixEn high advances xPos by one. After xPos reaches 799 it returns to 0 and yPos advances by one. After yPos reaches 524 it returns to 0. Without pixEn both coordinates hold.
- R3: The hSync value shown after the pixel step that fetched column x is low exactly when 656 <= x <= 751.
- R4: The vSync value shown after the pixel step that fetched line y is low exactly when y is 490 or 491.
- R5: The active value shown after the pixel step at (x, y) is high exactly when x < 640 and y < 480.
- R6: Whenever rdEn is high, rdAddr equals (yPos>>1)*320 + (xPos>>1).
- R7: rdEn is high exactly in cycles where pixEn and displayMode are high and xPos < 640 and yPos < 480.
- R8: After a pixel step at a visible position taken with displayMode high, red = rdData[11:8], green = rdData[7:4] and blue = rdData[3:0].
- R9: After a pixel step at a non-visible position, or one taken with displayMode low, red, green and blue are all zero.
- R10: hSync, vSync, active, red, green and blue change only at the clock edge of a cycle with pixEn high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel-step enable, one cycle per pixel |
| displayMode | input | 1 | High selects display: frame buffer reads allowed |
| rdData | input | 12 | Frame buffer word, RGB444, valid the cycle after rdEn |
| rdEn | output | 1 | Frame buffer read strobe |
| rdAddr | output | 17 | Frame buffer word address |
| xPos | output | 10 | Column being fetched |
| yPos | output | 10 | Line being fetched |
| hSync | output | 1 | Horizontal sync, active low, aligned to RGB |
| vSync | output | 1 | Vertical sync, active low, aligned to RGB |
| active | output | 1 | Active video, aligned to RGB |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |

## Verification
The assertions assume several things about the environment. pixEn is a single-cycle strobe driven from the system clock domain. The memory returns data exactly one clock after rdEn and holds it until the next read. displayMode changes only between clock edges. The bench meets these assumptions with a behavioural synchronous memory that updates only on rdEn, and it drives pixEn and displayMode only at falling edges. It uses a reduced raster so that several frame wraps fit in the run. It varies the step pattern (every cycle, one in four, two in three) and toggles display mode in the middle of lines.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  // per-step strobes from the raster control to the fetch datapath
  typedef struct packed {
    logic step;     // pixel step this cycle
    logic show;     // display mode sampled with this step
    logic visible;  // current position inside the visible area
    logic hSyncN;   // raw horizontal sync (low asserted)
    logic vSyncN;   // raw vertical sync (low asserted)
    logic fetch;    // issue a frame buffer read this cycle
  } scanStrobes_t;
endpackage

// File: rtl/vga_scan_ctrl.sv
module vga_scan_ctrl
  import vga_scan_pkg::*;
#(
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_VIS = 480,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP = 33,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pixEn,
  input  logic          displayMode,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output scanStrobes_t  strobes
);
  localparam int H_SYNC_START = H_VIS + H_FP;
  localparam int H_SYNC_END = H_SYNC_START + H_SYNC;
  localparam int V_SYNC_START = V_VIS + V_FP;
  localparam int V_SYNC_END = V_SYNC_START + V_SYNC;

  logic lineLast;
  logic frameLast;

  assign lineLast = (int'(hCount) == H_TOTAL - 1);
  assign frameLast = (int'(vCount) == V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else if (pixEn) begin
      if (lineLast) begin
        hCount <= '0;
        vCount <= frameLast ? '0 : vCount + 1'b1;
      end else begin
        hCount <= hCount + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.step = pixEn;
    strobes.show = displayMode;
    strobes.visible = (int'(hCount) < H_VIS) && (int'(vCount) < V_VIS);
    strobes.hSyncN = !((int'(hCount) >= H_SYNC_START) && (int'(hCount) < H_SYNC_END));
    strobes.vSyncN = !((int'(vCount) >= V_SYNC_START) && (int'(vCount) < V_SYNC_END));
    strobes.fetch = pixEn && displayMode && strobes.visible;
  end
endmodule

// File: rtl/vga_fetch_path.sv
module vga_fetch_path
  import vga_scan_pkg::*;
#(
  parameter int H_VIS = 640,
  parameter int V_VIS = 480,
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int PIX_W = 12,
  localparam int HALF_W = H_VIS / 2,
  localparam int HALF_H = V_VIS / 2,
  localparam int AW = $clog2(HALF_W * HALF_H),
  localparam int CH_W = PIX_W / 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HW-1:0]    hCount,
  input  logic [VW-1:0]    vCount,
  input  scanStrobes_t     strobes,
  input  logic [PIX_W-1:0] rdData,
  output logic [AW-1:0]    rdAddr,
  output logic             hSync,
  output logic             vSync,
  output logic             active,
  output logic [CH_W-1:0]  red,
  output logic [CH_W-1:0]  green,
  output logic [CH_W-1:0]  blue
);
  logic showDly;

  // each stored word covers a 2x2 screen square
  assign rdAddr = AW'(int'(vCount >> 1) * HALF_W + int'(hCount >> 1));

  // align sync, active and mode with the one-cycle memory latency
  always_ff @(posedge clk) begin
    if (rst) begin
      hSync <= 1'b1;
      vSync <= 1'b1;
      active <= 1'b0;
      showDly <= 1'b0;
    end else if (strobes.step) begin
      hSync <= strobes.hSyncN;
      vSync <= strobes.vSyncN;
      active <= strobes.visible;
      showDly <= strobes.show;
    end
  end

  always_comb begin
    if (active && showDly) begin
      red = rdData[3*CH_W-1:2*CH_W];
      green = rdData[2*CH_W-1:CH_W];
      blue = rdData[CH_W-1:0];
    end else begin
      red = '0;
      green = '0;
      blue = '0;
    end
  end
endmodule

// File: rtl/vga_scan_fetch.sv
module vga_scan_fetch
  import vga_scan_pkg::*;
#(
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_VIS = 480,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP = 33,
  parameter int PIX_W = 12,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int AW = $clog2((H_VIS / 2) * (V_VIS / 2)),
  localparam int CH_W = PIX_W / 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixEn,
  input  logic             displayMode,
  input  logic [PIX_W-1:0] rdData,
  output logic             rdEn,
  output logic [AW-1:0]    rdAddr,
  output logic [HW-1:0]    xPos,
  output logic [VW-1:0]    yPos,
  output logic             hSync,
  output logic             vSync,
  output logic             active,
  output logic [CH_W-1:0]  red,
  output logic [CH_W-1:0]  green,
  output logic [CH_W-1:0]  blue
);
  scanStrobes_t strobes;

  vga_scan_ctrl #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) ctrl (
    .clk(clk), .rst(rst), .pixEn(pixEn), .displayMode(displayMode),
    .hCount(xPos), .vCount(yPos), .strobes(strobes)
  );

  vga_fetch_path #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .HW(HW), .VW(VW), .PIX_W(PIX_W)
  ) path (
    .clk(clk), .rst(rst), .hCount(xPos), .vCount(yPos), .strobes(strobes),
    .rdData(rdData), .rdAddr(rdAddr), .hSync(hSync), .vSync(vSync),
    .active(active), .red(red), .green(green), .blue(blue)
  );

  assign rdEn = strobes.fetch;
endmodule

// File: rtl/vga_scan_fetch_chk.sv
module vga_scan_fetch_chk #(
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_VIS = 480,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP = 33,
  parameter int PIX_W = 12,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int AW = $clog2((H_VIS / 2) * (V_VIS / 2)),
  localparam int CH_W = PIX_W / 3
) (
  input logic            clk,
  input logic            rst,
  input logic            pixEn,
  input logic            displayMode,
  input logic            rdEn,
  input logic [AW-1:0]   rdAddr,
  input logic [HW-1:0]   xPos,
  input logic [VW-1:0]   yPos,
  input logic            hSync,
  input logic            vSync,
  input logic            active,
  input logic [CH_W-1:0] red,
  input logic [CH_W-1:0] green,
  input logic [CH_W-1:0] blue
);
  localparam int WORDS = (H_VIS / 2) * (V_VIS / 2);

  assert_coord_range_R2: assert property (@(posedge clk) disable iff (rst)
    (int'(xPos) < H_TOTAL) && (int'(yPos) < V_TOTAL));

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (pixEn && int'(xPos) == H_TOTAL - 1) |=> (xPos == '0));

  assert_addr_range_R6: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (int'(rdAddr) < WORDS));

  assert_fetch_gate_R7: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (pixEn && displayMode && int'(xPos) < H_VIS && int'(yPos) < V_VIS));

  assert_blank_rgb_R9: assert property (@(posedge clk) disable iff (rst)
    !active |-> (red == '0 && green == '0 && blue == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> ($stable(hSync) && $stable(vSync) && $stable(active)));
endmodule

bind vga_scan_fetch vga_scan_fetch_chk #(
  .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .PIX_W(PIX_W)
) chk (
  .clk(clk), .rst(rst), .pixEn(pixEn), .displayMode(displayMode),
  .rdEn(rdEn), .rdAddr(rdAddr), .xPos(xPos), .yPos(yPos),
  .hSync(hSync), .vSync(vSync), .active(active),
  .red(red), .green(green), .blue(blue)
);

// File: tb/tb_vga_scan_fetch.sv
module tb_vga_scan_fetch;
  // reduced raster so several frames fit in the run
  localparam int HV = 16, HFP = 2, HS = 3, HBP = 2;
  localparam int VV = 8, VFP = 1, VS = 2, VBP = 2;
  localparam int HT = HV + HFP + HS + HBP;
  localparam int VT = VV + VFP + VS + VBP;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);
  localparam int AW = $clog2((HV / 2) * (VV / 2));

  typedef struct packed {
    logic hs;
    logic vs;
    logic act;
    logic [11:0] rgb;
    logic stepped;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixEn = 1'b0;
  logic displayMode = 1'b0;
  logic [11:0] rdData;
  logic rdEn;
  logic [AW-1:0] rdAddr;
  logic [HW-1:0] xPos;
  logic [VW-1:0] yPos;
  logic hSync, vSync, active;
  logic [3:0] red, green, blue;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit monOn = 1'b0;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  vga_scan_fetch #(
    .H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .PIX_W(12)
  ) dut (
    .clk(clk), .rst(rst), .pixEn(pixEn), .displayMode(displayMode),
    .rdData(rdData), .rdEn(rdEn), .rdAddr(rdAddr), .xPos(xPos), .yPos(yPos),
    .hSync(hSync), .vSync(vSync), .active(active),
    .red(red), .green(green), .blue(blue)
  );

  function automatic logic [11:0] patt(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b[3:0], ~b[3:0], b[4:1]};
  endfunction

  // behavioural memory: one-cycle read, holds between reads
  always @(posedge clk) if (rdEn) rdData <= patt(int'(rdAddr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model state
  int hM = 0;
  int vM = 0;
  expItem_t lastExp;

  task automatic stepCycle(input bit en, input bit md);
    bit vis;
    int addr;
    expItem_t e;
    pixEn = en;
    displayMode = md;
    #1;
    vis = (hM < HV) && (vM < VV);
    addr = (vM / 2) * (HV / 2) + hM / 2;
    check(int'(xPos) == hM, "R2 xPos", int'(xPos), hM);
    check(int'(yPos) == vM, "R2 yPos", int'(yPos), vM);
    check(rdEn == (en && md && vis), "R7 rdEn", int'(rdEn), int'(en && md && vis));
    if (rdEn) check(int'(rdAddr) == addr, "R6 rdAddr", int'(rdAddr), addr);
    if (en) begin
      e.hs = !(hM >= HV + HFP && hM < HV + HFP + HS);
      e.vs = !(vM >= VV + VFP && vM < VV + VFP + VS);
      e.act = vis;
      e.rgb = (vis && md) ? patt(addr) : 12'h000;
      e.stepped = 1'b1;
      lastExp = e;
      if (hM == HT - 1) begin
        hM = 0;
        vM = (vM == VT - 1) ? 0 : vM + 1;
      end else begin
        hM = hM + 1;
      end
    end else begin
      e = lastExp;
      e.stepped = 1'b0;
    end
    expQ.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare outputs after each edge against the queue
  always @(posedge clk) begin
    if (monOn) begin
      expItem_t e;
      logic [11:0] got;
      #2;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        got = {red, green, blue};
        if (e.stepped) begin
          check(hSync == e.hs, "R3 hSync", int'(hSync), int'(e.hs));
          check(vSync == e.vs, "R4 vSync", int'(vSync), int'(e.vs));
          check(active == e.act, "R5 active", int'(active), int'(e.act));
          if (e.rgb != 12'h000 || e.act)
            check(got == e.rgb, (e.rgb == 12'h000 && !e.act) ? "R9 rgb" : "R8 rgb", int'(got), int'(e.rgb));
          else
            check(got == 12'h000, "R9 rgb blank", int'(got), 0);
        end else begin
          check(hSync == e.hs && vSync == e.vs && active == e.act,
                "R10 hold sync", int'({hSync, vSync, active}), int'({e.hs, e.vs, e.act}));
          check(got == e.rgb, "R10 hold rgb", int'(got), int'(e.rgb));
        end
      end
    end
  end

  initial begin
    lastExp = '{hs: 1'b1, vs: 1'b1, act: 1'b0, rgb: 12'h000, stepped: 1'b0};
    repeat (3) @(negedge clk);
    // R1 during reset
    check(hSync && vSync && !active, "R1 sync in reset", int'({hSync, vSync, active}), 6);
    check({red, green, blue} == 12'h000, "R1 rgb in reset", int'({red, green, blue}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(xPos == '0 && yPos == '0, "R1 coords after reset", int'({xPos, yPos}), 0);
    check(hSync && vSync && !active, "R1 sync after reset", int'({hSync, vSync, active}), 6);
    monOn = 1'b1;
    // every cycle, display on: covers a frame wrap
    for (int i = 0; i < 350; i++) stepCycle(1'b1, 1'b1);
    // pixel rate of one in four cycles
    for (int i = 0; i < 400; i++) stepCycle(i % 4 == 0, 1'b1);
    // display mode toggling within lines
    for (int i = 0; i < 320; i++) stepCycle(1'b1, (i / 7) % 2 == 1);
    // receive mode, irregular steps
    for (int i = 0; i < 60; i++) stepCycle(i % 3 != 0, 1'b0);
    stepCycle(1'b0, 1'b0);
    stepCycle(1'b0, 1'b0);
    monOn = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule